// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation converter. A processor raises a start strobe. The sequencer then searches for the code of the analog input one bit at a time, from the most significant bit down to the least significant. For each bit it sets that bit in a trial code that goes to an external DAC. It waits one clock for the DAC to settle. It then samples a single comparator bit, which says whether the DAC level is above the input, and keeps or drops the trial bit.

When the last bit has been decided, the code is copied into a result latch and an end-of-conversion flag goes high. The processor can poll that flag or wire it to an interrupt. The result reaches the processor's data bus only while a read enable is held. At all other times the bus lanes carry zero and a valid flag is low, which stands in for an undriven three-state output. The DAC, the comparator, the sample-and-hold and any input selection are outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `eoc` is 0, `dac_code` is all zeros, `bus_valid` is 0 and the stored result is zero.
- R2: A start strobe that is sampled high while the block is idle begins a conversion. At the next clock edge `dac_code` shows only the most significant bit set.
- R3: Bits are tried strictly from the MSB down to the LSB. Each trial code is held for two clocks, and the comparator is sampled on the second clock edge. While bit j is on trial, `dac_code` holds the decided bits above j, a 1 at bit j and zeros below j.
- R4: When the comparator is sampled, `cmp_above`=1 (DAC level above the input) clears the trial bit and `cmp_above`=0 keeps it set.
- R5: `eoc` rises exactly 2·N clock edges after the edge that accepted the start, where N is `WIDTH`. With an ideal DAC and comparator the result equals floor(input).
- R6: A start strobe that arrives while a conversion is running is ignored. The result, the trial sequence and the completion time stay unchanged.
- R7: `eoc` stays high until the next start is accepted, and it is low from the clock edge that accepts that start.
- R8: While `rd_en` is 1, `bus_data` equals the stored result and `bus_valid` is 1. While `rd_en` is 0, `bus_data` is zero and `bus_valid` is 0.
- R9: The stored result changes only when a conversion completes. During a new conversion it still reads the previous result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start-conversion strobe from the processor |
| cmp_above | input | 1 | Comparator: 1 when the DAC level exceeds the analog input |
| dac_code | output | WIDTH | Trial code driven to the external DAC |
| eoc | output | 1 | End of conversion; status bit or interrupt |
| rd_en | input | 1 | Read enable that gates the result onto the bus |
| bus_data | output | WIDTH | Result lanes; zero when not enabled |
| bus_valid | output | 1 | Marks the bus lanes as driven |

## Verification
On every cycle the assertions check four things: the bit pointer is one-hot or empty, the keep/clear rule applied at each comparator sample, that the trial code does not move during the settle cycle, and that the pointer does not react to a start strobe mid-conversion. They also check that `eoc` is held and cleared correctly and that the stored result only changes at completion. The bench's scenarios cover what needs a model of the analog side: the exact 2·N completion time, the full trial-code sequence and floor(input) across fractional input levels. They also cover bus gating around reads and the reuse of the previous result while a later conversion is running.

// File: rtl/sar_pkg.sv
// Package: shared types for the successive-approximation sequencer.
// Assumes: nothing beyond SystemVerilog 2017.
package sar_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_DECIDE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sar_sequencer.sv
// Module: sar_sequencer
// Steps the conversion through a settle clock and a decide clock for every
// bit, walking a one-hot pointer from MSB to LSB. Owns the end-of-convert flag.
// Assumes: start is synchronous to clk; a start seen outside idle is dropped.
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             decide,
    output logic             last,
    output logic [WIDTH-1:0] ptr,
    output logic             eoc
);
    localparam logic [WIDTH-1:0] PTR_MSB = {1'b1, {(WIDTH-1){1'b0}}};

    seq_state_t state;

    // Decode the control strobes from the current state.
    always_comb begin
        load   = (state == SEQ_IDLE) && start;
        decide = (state == SEQ_DECIDE);
        last   = decide && ptr[0];
    end

    // State register: idle -> settle -> decide -> (settle | idle).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE:   if (start) state <= SEQ_SETTLE;
                SEQ_SETTLE: state <= SEQ_DECIDE;
                SEQ_DECIDE: state <= ptr[0] ? SEQ_IDLE : SEQ_SETTLE;
                default:    state <= SEQ_IDLE;
            endcase
        end
    end

    // Bit pointer: MSB on load, shifts right after every decision.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (load)   ptr <= PTR_MSB;
        else if (decide) ptr <= ptr >> 1;
    end

    // End-of-convert flag: set at the final decision, cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)     eoc <= 1'b0;
        else if (load)  eoc <= 1'b0;
        else if (last)  eoc <= 1'b1;
    end

    assert_ptr_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr));

    assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_SETTLE && start) |=> $stable(ptr));

    assert_eoc_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !eoc);

    assert_eoc_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && !load) |=> eoc);
endmodule

// File: rtl/sar_trial_reg.sv
// Module: sar_trial_reg
// Holds the trial code seen by the DAC. Each bit is one generated slice that
// is set when the pointer arrives just above it, and is kept or dropped when
// the comparator is sampled for it.
// Assumes: ptr is one-hot or zero; load and decide are never high together.
module sar_trial_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             decide,
    input  logic             cmp_above,
    input  logic [WIDTH-1:0] ptr,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] decided
);
    // Code after applying the current comparator sample to the bit on trial.
    always_comb decided = trial & ~(ptr & {WIDTH{cmp_above}});

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_top
            // MSB slice: set on load, resolved on its own decision.
            always_ff @(posedge clk) begin
                if (!rst_n)                 trial[i] <= 1'b0;
                else if (load)              trial[i] <= 1'b1;
                else if (decide && ptr[i])  trial[i] <= trial[i] & ~cmp_above;
            end
        end else begin : g_low
            // Lower slice: cleared on load, set when the bit above is decided.
            always_ff @(posedge clk) begin
                if (!rst_n)                   trial[i] <= 1'b0;
                else if (load)                trial[i] <= 1'b0;
                else if (decide && ptr[i])    trial[i] <= trial[i] & ~cmp_above;
                else if (decide && ptr[i+1])  trial[i] <= 1'b1;
            end
        end
    end

    assert_clear_when_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && cmp_above) |=> ((trial & $past(ptr)) == '0));

    assert_keep_when_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !cmp_above) |=> ((trial & $past(ptr)) == $past(ptr)));

    assert_settle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !decide) |=> $stable(trial));
endmodule

// File: rtl/sar_result_port.sv
// Module: sar_result_port
// Latches the finished code and presents it on a gated bus. With the read
// enable low the lanes are zero and the valid flag is low (undriven bus).
// Assumes: capture pulses for one clock at the end of a conversion.
module sar_result_port #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] code_in,
    input  logic             rd_en,
    output logic [WIDTH-1:0] bus_data,
    output logic             bus_valid
);
    logic [WIDTH-1:0] result_q;

    // Result latch: only loads at the final decision.
    always_ff @(posedge clk) begin
        if (!rst_n)       result_q <= '0;
        else if (capture) result_q <= code_in;
    end

    // Bus gate: drive the lanes only while the reader asks.
    always_comb begin
        bus_valid = rd_en;
        bus_data  = rd_en ? result_q : '0;
    end

    assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(result_q));
endmodule

// File: rtl/sar_conv_ctrl.sv
// Module: sar_conv_ctrl (top)
// Successive-approximation sequencer with a start / end-of-convert handshake
// and a gated result read.
// Assumes: the external comparator output settles within one clock of a new
// trial code.
module sar_conv_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_above,
    output logic [WIDTH-1:0] dac_code,
    output logic             eoc,
    input  logic             rd_en,
    output logic [WIDTH-1:0] bus_data,
    output logic             bus_valid
);
    logic             load;
    logic             decide;
    logic             last;
    logic [WIDTH-1:0] ptr;
    logic [WIDTH-1:0] trial;
    logic [WIDTH-1:0] decided;

    sar_sequencer #(.WIDTH(WIDTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .decide(decide), .last(last), .ptr(ptr), .eoc(eoc)
    );

    sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
        .clk(clk), .rst_n(rst_n), .load(load), .decide(decide),
        .cmp_above(cmp_above), .ptr(ptr), .trial(trial), .decided(decided)
    );

    sar_result_port #(.WIDTH(WIDTH)) u_port (
        .clk(clk), .rst_n(rst_n), .capture(last), .code_in(decided),
        .rd_en(rd_en), .bus_data(bus_data), .bus_valid(bus_valid)
    );

    // The DAC sees the trial register directly.
    always_comb dac_code = trial;
endmodule

// File: tb/sar_conv_ctrl_test.sv
// Bench for sar_conv_ctrl: ideal DAC and comparator, input in quarter-LSB units.
module sar_conv_ctrl_test;
    localparam int W = 8;
    localparam int NV = 10;
    localparam logic [W+1:0] VEC [NV] = '{
        10'd0, 10'd3, 10'd4, 10'd1023, 10'd512,
        10'd511, 10'd513, 10'd682, 10'd341, 10'd1020
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         rd_en = 1'b0;
    logic [W+1:0] vin4 = '0;
    logic         cmp_above;
    logic [W-1:0] dac_code;
    logic         eoc;
    logic [W-1:0] bus_data;
    logic         bus_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Ideal DAC + comparator: above when code exceeds the input.
    assign cmp_above = ({dac_code, 2'b00} > vin4);

    sar_conv_ctrl #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_above(cmp_above),
        .dac_code(dac_code), .eoc(eoc), .rd_en(rd_en),
        .bus_data(bus_data), .bus_valid(bus_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one conversion; optionally pulse start again at posedge count glitch.
    task automatic convert(input logic [W+1:0] v4, input int glitch, input logic [W-1:0] prev,
                           output int cycles, output logic seq_ok, output logic prev_ok);
        logic [W-1:0] exp_res;
        logic [W-1:0] exp_trial;
        int j;
        exp_res = v4[W+1:2];
        vin4 = v4;
        seq_ok = 1'b1;
        prev_ok = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cycles = 1;
        while (!eoc && cycles < 4 * W) begin
            j = W - 1 - (cycles - 1) / 2;
            exp_trial = ((exp_res >> (j + 1)) << (j + 1)) | (W'(1) << j);
            if (dac_code !== exp_trial) seq_ok = 1'b0;
            if (rd_en && bus_data !== prev) prev_ok = 1'b0;
            start = (cycles == glitch);
            @(negedge clk);
            start = 1'b0;
            cycles++;
        end
        cycles--;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int cyc;
        logic sq, pv;
        logic [W-1:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 eoc", eoc, 0);
        check("R1 dac_code", dac_code, 0);
        check("R1 bus_valid", bus_valid, 0);
        rd_en = 1'b1;
        #1 check("R1 result", bus_data, 0);
        rd_en = 1'b0;

        // R2: MSB only after the accepting edge
        vin4 = 10'd600;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R2 msb trial", dac_code, 8'h80);
        repeat (2 * W + 2) @(negedge clk);

        // R3 R4 R5: vector table
        prev = 8'd150;
        for (int k = 0; k < NV; k++) begin
            convert(VEC[k], 0, prev, cyc, sq, pv);
            check("R5 cycles", cyc, 2 * W);
            check("R3 R4 trial sequence", sq, 1);
            rd_en = 1'b1;
            #1 check("R5 floor result", bus_data, VEC[k] >> 2);
            check("R8 valid when read", bus_valid, 1);
            rd_en = 1'b0;
            #1 check("R8 lanes idle", bus_data, 0);
            check("R8 valid low", bus_valid, 0);
            prev = VEC[k] >> 2;
        end

        // R7: eoc holds across idle clocks, then clears on new start
        repeat (5) @(negedge clk);
        check("R7 eoc held", eoc, 1);
        vin4 = 10'd100;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R7 eoc cleared", eoc, 0);
        repeat (2 * W + 2) @(negedge clk);
        prev = 8'd25;

        // R6 + R9: start mid-conversion ignored, previous result readable
        rd_en = 1'b1;
        convert(10'd877, 5, prev, cyc, sq, pv);
        check("R6 cycles unchanged", cyc, 2 * W);
        check("R6 sequence unchanged", sq, 1);
        check("R9 previous result during run", pv, 1);
        #1 check("R6 result", bus_data, 219);
        rd_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule